// File: doc/BRIEF.md
# Textured Column Rasterizer

The block is a bus-master drawing engine that fills one vertical strip of an 8-bit framebuffer from a texture column. Software sets up the job through a small register port: the texture column base, the base of a 256-entry light-remap table, the first destination byte address, a 16.16 fixed-point starting texture coordinate, the per-pixel coordinate step, a wrap limit and a pixel count. A write to the start register launches the strip, and the processor is then free to do other work while the engine runs on its own.

For every pixel the engine reads one texel at the integer part of the coordinate, uses that texel as an index into the remap table, reads the remapped value and stores it as a byte at the current destination. It then moves the destination down one screen line of 320 bytes and advances the coordinate by the step, subtracting the wrap limit whenever the new coordinate reaches or passes it. Memory traffic goes through a plain request/acknowledge port with one request in flight at a time. A status register reports a busy bit and a sticky done flag.

Top module: `col_raster`

## Requirements
- R1: The first request of each pixel is a read (mem_we low) at address texture_base + (coord >> 16), the coordinate's upper 16 bits zero-extended.
- R2: The second request of each pixel is a read at address remap_base + texel, where texel is the 8-bit data returned by the first read; the third request is a byte write (mem_we high) whose data is the 8-bit value returned by the second read.
- R3: The write of the first pixel goes to the programmed destination; each later pixel's write address is 320 greater than the previous one.
- R4: After each pixel the coordinate becomes coord + step (modulo 2^32); if that sum is greater than or equal to the wrap limit (unsigned), the wrap limit is subtracted from it.
- R5: A strip draws exactly the programmed count of pixels (3 × count requests) and then sets done and clears busy.
- R6: A start with a count of zero issues no memory request, leaves busy low and sets done at once.
- R7: Reading offset 8 returns busy in bit 0 and done in bit 1; done stays set until software writes the start register (offset 7) while idle, which clears it; busy and done are never both set.
- R8: mem_req stays high with address, direction and write data unchanged until mem_ack; a new request is presented only in the cycle after an acknowledge, and a write acknowledge is always followed by a read or by no request.
- R9: Configuration writes while busy do not change the strip in progress (values are captured at start), and writes to the start register while busy are ignored.
- R10: Register offsets are 0 texture base, 1 remap base, 2 destination, 3 coordinate, 4 step, 5 wrap limit, 6 count; each reads back the last value written, one cycle after the address is presented.
- R11: After reset mem_req is low and the status register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for reg_addr |
| mem_req | output | 1 | Memory request valid, held until acknowledged |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | 32 | Byte address of the request |
| mem_wdata | output | 8 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid in this cycle |
| mem_rdata | input | 8 | Read data, sampled with mem_ack |

## Verification
A corrupted coordinate or destination register shows up at the memory port on the very next pixel as a wrong texel or store address, so the scoreboard compares every acknowledged request against an independently computed list and flags the first deviating transaction. A sequencer that skips or reorders a phase breaks the read-read-write pattern at the next acknowledge, and a miscounting pixel counter leaves entries in the queue or produces an unexpected request when the strip ends. Status faults appear on the next status read, in particular around the zero-count start and the start write issued while busy.

// File: rtl/col_raster_pkg.sv
package col_raster_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TEXEL = 2'd1,
    ST_REMAP = 2'd2,
    ST_STORE = 2'd3
  } seq_state_t;

  localparam int REG_AW     = 4;
  localparam int NUM_CFG    = 7;

  localparam logic [REG_AW-1:0] OFS_TEX    = 4'd0;
  localparam logic [REG_AW-1:0] OFS_LUT    = 4'd1;
  localparam logic [REG_AW-1:0] OFS_DEST   = 4'd2;
  localparam logic [REG_AW-1:0] OFS_COORD  = 4'd3;
  localparam logic [REG_AW-1:0] OFS_STEP   = 4'd4;
  localparam logic [REG_AW-1:0] OFS_WRAP   = 4'd5;
  localparam logic [REG_AW-1:0] OFS_COUNT  = 4'd6;
  localparam logic [REG_AW-1:0] OFS_GO     = 4'd7;
  localparam logic [REG_AW-1:0] OFS_STATUS = 4'd8;

endpackage

// File: rtl/col_raster_regs.sv
module col_raster_regs
  import col_raster_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      reg_we,
  input  logic [REG_AW-1:0]         reg_addr,
  input  logic [DATA_W-1:0]         reg_wdata,
  output logic [DATA_W-1:0]         reg_rdata,
  input  logic                      busy,
  input  logic                      done,
  output logic [NUM_CFG*DATA_W-1:0] cfg_flat,
  output logic                      start
);

  logic [DATA_W-1:0] cfg_q [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (reg_we && reg_addr == REG_AW'(g)) begin
        cfg_q[g] <= reg_wdata;
      end
    end
    assign cfg_flat[g*DATA_W +: DATA_W] = cfg_q[g];
  end

  assign start = reg_we && (reg_addr == OFS_GO) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_addr < REG_AW'(NUM_CFG)) begin
      reg_rdata <= cfg_q[reg_addr[2:0]];
    end else if (reg_addr == OFS_STATUS) begin
      reg_rdata <= {{(DATA_W-2){1'b0}}, done, busy};
    end else begin
      reg_rdata <= '0;
    end
  end

endmodule

// File: rtl/col_raster_coord.sv
module col_raster_coord #(
  parameter int COORD_W = 32
) (
  input  logic [COORD_W-1:0] coord,
  input  logic [COORD_W-1:0] step,
  input  logic [COORD_W-1:0] wrap,
  output logic [COORD_W-1:0] coord_next
);

  logic [COORD_W-1:0] sum;

  always_comb begin
    sum = coord + step;
    if (sum >= wrap) begin
      coord_next = sum - wrap;
    end else begin
      coord_next = sum;
    end
  end

endmodule

// File: rtl/col_raster_seq.sv
module col_raster_seq
  import col_raster_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 32,
  parameter int FRAC_W  = 16,
  parameter int CNT_W   = 32,
  parameter int PIX_W   = 8,
  parameter int STRIDE  = 320
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [ADDR_W-1:0]  cfg_tex,
  input  logic [ADDR_W-1:0]  cfg_lut,
  input  logic [ADDR_W-1:0]  cfg_dest,
  input  logic [COORD_W-1:0] cfg_coord,
  input  logic [COORD_W-1:0] cfg_step,
  input  logic [COORD_W-1:0] cfg_wrap,
  input  logic [CNT_W-1:0]   cfg_count,
  output logic               mem_req,
  output logic               mem_we,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [PIX_W-1:0]   mem_wdata,
  input  logic               mem_ack,
  input  logic [PIX_W-1:0]   mem_rdata,
  output logic               busy,
  output logic               done
);

  localparam int IDX_W = COORD_W - FRAC_W;

  seq_state_t         state_q;
  logic [ADDR_W-1:0]  tex_q, lut_q, dest_q;
  logic [COORD_W-1:0] coord_q, step_q, wrap_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [COORD_W-1:0] coord_nx;

  col_raster_coord #(.COORD_W(COORD_W)) u_coord (
    .coord      (coord_q),
    .step       (step_q),
    .wrap       (wrap_q),
    .coord_next (coord_nx)
  );

  function automatic logic [ADDR_W-1:0] texel_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [COORD_W-1:0] c);
    logic [IDX_W-1:0] idx;
    idx = c[COORD_W-1:FRAC_W];
    return base + ADDR_W'(idx);
  endfunction

  assign busy = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      tex_q     <= '0;
      lut_q     <= '0;
      dest_q    <= '0;
      coord_q   <= '0;
      step_q    <= '0;
      wrap_q    <= '0;
      cnt_q     <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            tex_q   <= cfg_tex;
            lut_q   <= cfg_lut;
            dest_q  <= cfg_dest;
            coord_q <= cfg_coord;
            step_q  <= cfg_step;
            wrap_q  <= cfg_wrap;
            cnt_q   <= cfg_count;
            if (cfg_count == '0) begin
              done <= 1'b1;
            end else begin
              done     <= 1'b0;
              state_q  <= ST_TEXEL;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= texel_addr(cfg_tex, cfg_coord);
            end
          end
        end
        ST_TEXEL: begin
          if (mem_ack) begin
            mem_addr <= lut_q + ADDR_W'(mem_rdata);
            state_q  <= ST_REMAP;
          end
        end
        ST_REMAP: begin
          if (mem_ack) begin
            mem_we    <= 1'b1;
            mem_wdata <= mem_rdata;
            mem_addr  <= dest_q;
            state_q   <= ST_STORE;
          end
        end
        ST_STORE: begin
          if (mem_ack) begin
            dest_q  <= dest_q + ADDR_W'(STRIDE);
            coord_q <= coord_nx;
            cnt_q   <= cnt_q - 1'b1;
            mem_we  <= 1'b0;
            if (cnt_q == CNT_W'(1)) begin
              state_q <= ST_IDLE;
              mem_req <= 1'b0;
              done    <= 1'b1;
            end else begin
              state_q  <= ST_TEXEL;
              mem_addr <= texel_addr(tex_q, coord_nx);
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/col_raster.sv
module col_raster
  import col_raster_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 32,
  parameter int COORD_W = 32,
  parameter int FRAC_W  = 16,
  parameter int CNT_W   = 32,
  parameter int PIX_W   = 8,
  parameter int STRIDE  = 320
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic              mem_ack,
  input  logic [PIX_W-1:0]  mem_rdata
);

  logic                      busy_w, done_w, start_w;
  logic [NUM_CFG*DATA_W-1:0] cfg_flat;

  col_raster_regs #(.DATA_W(DATA_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy_w),
    .done      (done_w),
    .cfg_flat  (cfg_flat),
    .start     (start_w)
  );

  col_raster_seq #(
    .ADDR_W (ADDR_W), .COORD_W(COORD_W), .FRAC_W(FRAC_W),
    .CNT_W  (CNT_W),  .PIX_W  (PIX_W),   .STRIDE(STRIDE)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (start_w),
    .cfg_tex   (cfg_flat[0*DATA_W +: ADDR_W]),
    .cfg_lut   (cfg_flat[1*DATA_W +: ADDR_W]),
    .cfg_dest  (cfg_flat[2*DATA_W +: ADDR_W]),
    .cfg_coord (cfg_flat[3*DATA_W +: COORD_W]),
    .cfg_step  (cfg_flat[4*DATA_W +: COORD_W]),
    .cfg_wrap  (cfg_flat[5*DATA_W +: COORD_W]),
    .cfg_count (cfg_flat[6*DATA_W +: CNT_W]),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .mem_rdata (mem_rdata),
    .busy      (busy_w),
    .done      (done_w)
  );

endmodule

// File: rtl/col_raster_chk.sv
module col_raster_chk #(
  parameter int ADDR_W = 32,
  parameter int PIX_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_we,
  input logic [3:0]        reg_addr,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [PIX_W-1:0]  mem_wdata,
  input logic              mem_ack,
  input logic              busy,
  input logic              done
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R8

  AST_STORE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_ack && mem_we |=> !mem_we); // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req); // R6

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done && !(reg_we && reg_addr == 4'd7) |=> done); // R7

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    busy |-> !done); // R7

endmodule

bind col_raster col_raster_chk #(.ADDR_W(ADDR_W), .PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .busy      (busy_w),
  .done      (done_w)
);

// File: tb/col_raster_bench.sv
module col_raster_bench;

  localparam int CLK_PERIOD = 10;
  localparam int STRIDE     = 320;

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [7:0]  data;
  } txn_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ack = 1'b0;
  logic [7:0]  mem_rdata = '0;

  int   vec_cnt = 0;
  int   err_cnt = 0;
  int   txn_cnt = 0;
  bit   finished = 1'b0;
  txn_t exp_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  col_raster u_col_raster (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_val(input logic [31:0] a);
    return (a[7:0] * 8'd13) ^ a[15:8] ^ 8'h21;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
      $finish;
    end
  endtask

  // Memory model and monitor: compares each acknowledged request to the scoreboard
  initial begin
    int lat_sel = 0;
    forever begin
      @(negedge clk);
      if (mem_req && !rst) begin
        repeat (lat_sel % 4) @(negedge clk);
        lat_sel++;
        txn_cnt++;
        if (exp_q.size() == 0) begin
          vec_cnt++; err_cnt++;
          $display("FAIL R5 unexpected request actual=%h expected=none", mem_addr);
        end else begin
          txn_t e;
          e = exp_q.pop_front();
          check("R8 direction", {31'd0, mem_we}, {31'd0, e.we});
          if (e.we) begin
            check("R3 store address", mem_addr, e.addr);
            check("R2 store data", {24'd0, mem_wdata}, {24'd0, e.data});
          end else begin
            check("R1/R2 read address", mem_addr, e.addr);
          end
        end
        mem_ack   = 1'b1;
        mem_rdata = mem_we ? 8'h00 : mem_val(mem_addr);
        @(negedge clk);
        mem_ack   = 1'b0;
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  // Driver: programs a strip and pushes its expected transactions (R1 R2 R3 R4)
  task automatic drive_strip(input logic [31:0] tex, input logic [31:0] lut,
                             input logic [31:0] dest, input logic [31:0] coord,
                             input logic [31:0] step, input logic [31:0] wrap,
                             input int count);
    logic [31:0] c, d;
    c = coord; d = dest;
    reg_write(4'd0, tex);
    reg_write(4'd1, lut);
    reg_write(4'd2, dest);
    reg_write(4'd3, coord);
    reg_write(4'd4, step);
    reg_write(4'd5, wrap);
    reg_write(4'd6, count);
    for (int i = 0; i < count; i++) begin
      logic [31:0] ta, la, s;
      logic [7:0]  tx, px;
      ta = tex + {16'd0, c[31:16]};
      tx = mem_val(ta);
      la = lut + {24'd0, tx};
      px = mem_val(la);
      exp_q.push_back('{1'b0, ta, 8'h00});
      exp_q.push_back('{1'b0, la, 8'h00});
      exp_q.push_back('{1'b1, d, px});
      d = d + STRIDE;
      s = c + step;
      c = (s >= wrap) ? s - wrap : s;
    end
    reg_write(4'd7, 32'd1);
  endtask

  task automatic wait_done(input string req);
    logic [31:0] st;
    int n = 0;
    st = '0;
    while (st[1] !== 1'b1 && n < 5000) begin
      reg_read(4'd8, st);
      n++;
    end
    check(req, st, 32'd2);
    check(req, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vec_cnt++; err_cnt++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int t0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    check("R11 mem_req", {31'd0, mem_req}, 32'd0);
    reg_read(4'd8, rd);
    check("R11 status", rd, 32'd0);

    // R10 register readback
    reg_write(4'd3, 32'hDEAD_BEEF);
    reg_write(4'd5, 32'h0040_0000);
    reg_read(4'd3, rd);
    check("R10 coord readback", rd, 32'hDEAD_BEEF);
    reg_read(4'd5, rd);
    check("R10 wrap readback", rd, 32'h0040_0000);

    // R5 plain strip, no wrap
    drive_strip(32'h0001_0000, 32'h0002_0000, 32'h0010_0000,
                32'h0000_8000, 32'h0001_4000, 32'h7FFF_0000, 6);
    wait_done("R5 strip of 6");

    // R4 wrap case: coordinate crosses the limit
    drive_strip(32'h0003_0100, 32'h0004_0000, 32'h0011_0040,
                32'h003F_0000, 32'h0001_8000, 32'h0040_0000, 5);
    wait_done("R4 wrapping strip");

    // R4 exact boundary: sum equals limit
    drive_strip(32'h0005_0000, 32'h0004_0100, 32'h0012_0000,
                32'h0002_0000, 32'h0001_0000, 32'h0004_0000, 4);
    wait_done("R4 boundary strip");

    // R7 done sticky across reads
    reg_read(4'd8, rd);
    check("R7 done sticky", rd, 32'd2);

    // R6 zero count
    t0 = txn_cnt;
    drive_strip(32'h0006_0000, 32'h0004_0000, 32'h0013_0000,
                32'h0000_0000, 32'h0001_0000, 32'h0010_0000, 0);
    reg_read(4'd8, rd);
    check("R6 zero count status", rd, 32'd2);
    repeat (5) @(negedge clk);
    check("R6 no memory access", txn_cnt - t0, 0);

    // R9 writes while busy are ignored by the running strip
    t0 = txn_cnt;
    drive_strip(32'h0007_0000, 32'h0008_0000, 32'h0014_0000,
                32'h0010_0000, 32'h0000_C000, 32'h0020_0000, 8);
    reg_read(4'd8, rd);
    check("R7 busy and done cleared by start", rd, 32'd1);
    reg_write(4'd2, 32'h0099_0000);
    reg_write(4'd3, 32'h0000_0000);
    reg_write(4'd6, 32'd2);
    reg_write(4'd7, 32'd1);
    wait_done("R9 strip unaffected");
    check("R9 transaction total", txn_cnt - t0, 24);
    reg_read(4'd2, rd);
    check("R10 dest holds new value", rd, 32'h0099_0000);

    repeat (5) @(negedge clk);
    check("R8 idle after strip", {31'd0, mem_req}, 32'd0);
    finish_run();
  end

endmodule